// File: doc/BRIEF.md
# Two-Wire Debug Entry Sequencer

This block produces the pin-level script that brings a target into two-wire debug mode. It drives two pins: a clock/test pin and a data/reset pin. After a start pulse it takes both pins as outputs. It walks them through a fixed list of levels and hold times, including one short low pulse on the clock/test pin that makes the target latch the two-wire selection. When the script ends it raises a one-cycle done pulse and passes pin ownership to a downstream shift engine.

Every hold time comes from a single down-counter. The counter is reloaded on each state change from a per-state constant. That constant is computed at elaboration from the `CLK_HZ` parameter and a time in nanoseconds, and is rounded up so that no minimum hold is shortened.

The states, with their pin levels (clock/test, data), are:
- IDLE (not driven)
- TRST (0,1, test-logic reset, ~4 ms)
- SETUP (0,1, ~1 us)
- ACTIVATE (1,1, ~20 ms)
- SELECT (1,1, ~60 us; a high data level chooses two-wire mode)
- LATCH (0,1, ~1 us pulse)
- SETTLE (1,1, ~60 us)
- FINAL (1,1, ~5 ms)
- HANDOFF (not driven, engine owns the pins)

The transitions are:
- IDLE→TRST and HANDOFF→TRST on start.
- Each timed state moves to the next one when its counter expires: TRST→SETUP→ACTIVATE→SELECT→LATCH→SETTLE→FINAL→HANDOFF.

Top module: `dbg2w_entry_seq`

## Requirements
- R1: After reset `busy_o`, `done_o`, `pins_oe_o` and `engine_sel_o` are 0, and they stay 0 without a start.
- R2: A start pulse in IDLE or HANDOFF is taken at that clock edge. From the next cycle `busy_o`=1, `pins_oe_o`=1, `tck_o`=0 and `tdio_o`=1.
- R3: `tck_o` stays low for exactly ceil(CLK_HZ·4 ms)+ceil(CLK_HZ·1 us) cycles from the first driven cycle, then rises.
- R4: `tck_o` then stays high for exactly ceil(CLK_HZ·20 ms)+ceil(CLK_HZ·60 us) cycles before the latch pulse.
- R5: The latch pulse holds `tck_o` low for exactly ceil(CLK_HZ·1 us) cycles. That duration lies between 25 ns and 7 us.
- R6: After the latch pulse `tck_o` stays high for exactly ceil(CLK_HZ·60 us)+ceil(CLK_HZ·5 ms) cycles, and `done_o` rises in the cycle after that.
- R7: Whenever `pins_oe_o`=1, `tdio_o`=1.
- R8: `done_o` is high for exactly one cycle. `busy_o` is 1 in every driven cycle and is 0 in the done cycle.
- R9: A start pulse while `busy_o`=1 has no effect: all pin intervals keep their R3–R6 lengths.
- R10: From the done cycle until the next start, `pins_oe_o`=0 and `engine_sel_o`=1. A start in this state runs the full script again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted when not busy |
| tck_o | output | 1 | Clock/test pin level |
| tdio_o | output | 1 | Data/reset pin level |
| pins_oe_o | output | 1 | Output enable for both pins |
| engine_sel_o | output | 1 | High once the shift engine owns the pins |
| busy_o | output | 1 | Script in progress |
| done_o | output | 1 | One-cycle pulse at the end of the script |

## Verification
The assertions assume that `start_i` is a synchronous level sampled at the clock edge and that reset is held for at least one edge. They also assume that no other agent drives the pins while `pins_oe_o` is high. The bench changes `start_i` only at falling edges. It raises start once from IDLE and once from HANDOFF. It pokes start again twice while busy: once on the edge right after acceptance and once deep inside ACTIVATE. These pokes exercise the ignore rule without ever breaking the synchronous-input assumption.

// File: rtl/dbg2w_pkg.sv
`timescale 1ns/1ps
package dbg2w_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TRST,
        ST_SETUP,
        ST_ACTIVATE,
        ST_SELECT,
        ST_LATCH,
        ST_SETTLE,
        ST_FINAL,
        ST_HANDOFF
    } seq_state_t;

    // Cycles needed to cover at least ns nanoseconds, never below one.
    function automatic longint unsigned ns_to_cycles(longint unsigned clk_hz,
                                                     longint unsigned ns);
        longint unsigned c;
        c = (clk_hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
        return (c == 0) ? 64'd1 : c;
    endfunction

    function automatic longint unsigned max2(longint unsigned a, longint unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dbg2w_hold_timer.sv
`timescale 1ns/1ps
module dbg2w_hold_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          expired_o
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    // Counter rests at zero until reloaded: holds never wrap. R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !load_i) |=> (cnt_q == '0)); // R3

    // A load always takes effect on the next edge. R4
    AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(load_val_i))); // R4

endmodule

// File: rtl/dbg2w_seq_fsm.sv
`timescale 1ns/1ps
module dbg2w_seq_fsm
    import dbg2w_pkg::*;
#(
    parameter int            CW            = 16,
    parameter logic [CW-1:0] LD_TRST       = '0,
    parameter logic [CW-1:0] LD_SETUP      = '0,
    parameter logic [CW-1:0] LD_ACTIVATE   = '0,
    parameter logic [CW-1:0] LD_SELECT     = '0,
    parameter logic [CW-1:0] LD_LATCH      = '0,
    parameter logic [CW-1:0] LD_SETTLE     = '0,
    parameter logic [CW-1:0] LD_FINAL      = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          expired_i,
    output seq_state_t    state_d_o,
    output logic          tmr_load_o,
    output logic [CW-1:0] tmr_val_o,
    output logic          busy_o,
    output logic          done_o
);

    seq_state_t state_q;
    seq_state_t state_d;
    logic       done_q;

    function automatic logic [CW-1:0] reload_of(seq_state_t s);
        logic [CW-1:0] v;
        unique case (s)
            ST_TRST:     v = LD_TRST;
            ST_SETUP:    v = LD_SETUP;
            ST_ACTIVATE: v = LD_ACTIVATE;
            ST_SELECT:   v = LD_SELECT;
            ST_LATCH:    v = LD_LATCH;
            ST_SETTLE:   v = LD_SETTLE;
            ST_FINAL:    v = LD_FINAL;
            default:     v = '0;
        endcase
        return v;
    endfunction

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_FINAL) && expired_i;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE,
            ST_HANDOFF:  if (start_i)   state_d = ST_TRST;
            ST_TRST:     if (expired_i) state_d = ST_SETUP;
            ST_SETUP:    if (expired_i) state_d = ST_ACTIVATE;
            ST_ACTIVATE: if (expired_i) state_d = ST_SELECT;
            ST_SELECT:   if (expired_i) state_d = ST_LATCH;
            ST_LATCH:    if (expired_i) state_d = ST_SETTLE;
            ST_SETTLE:   if (expired_i) state_d = ST_FINAL;
            ST_FINAL:    if (expired_i) state_d = ST_HANDOFF;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        tmr_load_o = (state_d != state_q);
        tmr_val_o  = reload_of(state_d);
        busy_o     = (state_q != ST_IDLE) && (state_q != ST_HANDOFF);
        done_o     = done_q;
        state_d_o  = state_d;
    end

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !expired_i) |=> (state_q == $past(state_q))); // R9

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R8

    AST_DONE_AFTER_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> ($past(state_q) == ST_FINAL && state_q == ST_HANDOFF)); // R6

    AST_NOT_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_o); // R8

endmodule

// File: rtl/dbg2w_pin_drv.sv
`timescale 1ns/1ps
module dbg2w_pin_drv
    import dbg2w_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_t state_d_i,
    output logic       tck_o,
    output logic       tdio_o,
    output logic       oe_o,
    output logic       engine_sel_o
);

    logic tck_n, tdio_n, oe_n, sel_n;

    always_comb begin
        tck_n  = 1'b1;
        tdio_n = 1'b1;
        oe_n   = 1'b0;
        sel_n  = 1'b0;
        unique case (state_d_i)
            ST_IDLE: ;
            ST_TRST,
            ST_SETUP,
            ST_LATCH: begin
                tck_n = 1'b0;
                oe_n  = 1'b1;
            end
            ST_ACTIVATE,
            ST_SELECT,
            ST_SETTLE,
            ST_FINAL: oe_n = 1'b1;
            ST_HANDOFF: sel_n = 1'b1;
            default: ;
        endcase
    end

    // Registered so the pins line up with the state register and never glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tck_o        <= 1'b1;
            tdio_o       <= 1'b1;
            oe_o         <= 1'b0;
            engine_sel_o <= 1'b0;
        end else begin
            tck_o        <= tck_n;
            tdio_o       <= tdio_n;
            oe_o         <= oe_n;
            engine_sel_o <= sel_n;
        end
    end

    AST_DATA_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        oe_o |-> tdio_o); // R7

    AST_OWNER_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(oe_o && engine_sel_o)); // R10

endmodule

// File: rtl/dbg2w_entry_seq.sv
`timescale 1ns/1ps
module dbg2w_entry_seq
    import dbg2w_pkg::*;
#(
    parameter int unsigned CLK_HZ        = 50_000_000,
    parameter int unsigned T_TRST_NS     = 4_000_000,
    parameter int unsigned T_SETUP_NS    = 1_000,
    parameter int unsigned T_ACTIVATE_NS = 20_000_000,
    parameter int unsigned T_SELECT_NS   = 60_000,
    parameter int unsigned T_LATCH_NS    = 1_000,
    parameter int unsigned T_SETTLE_NS   = 60_000,
    parameter int unsigned T_FINAL_NS    = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic tck_o,
    output logic tdio_o,
    output logic pins_oe_o,
    output logic engine_sel_o,
    output logic busy_o,
    output logic done_o
);

    localparam longint unsigned C_TRST     = ns_to_cycles(CLK_HZ, T_TRST_NS);
    localparam longint unsigned C_SETUP    = ns_to_cycles(CLK_HZ, T_SETUP_NS);
    localparam longint unsigned C_ACTIVATE = ns_to_cycles(CLK_HZ, T_ACTIVATE_NS);
    localparam longint unsigned C_SELECT   = ns_to_cycles(CLK_HZ, T_SELECT_NS);
    localparam longint unsigned C_LATCH    = ns_to_cycles(CLK_HZ, T_LATCH_NS);
    localparam longint unsigned C_SETTLE   = ns_to_cycles(CLK_HZ, T_SETTLE_NS);
    localparam longint unsigned C_FINAL    = ns_to_cycles(CLK_HZ, T_FINAL_NS);
    localparam longint unsigned C_MAX =
        max2(max2(max2(C_TRST, C_SETUP), max2(C_ACTIVATE, C_SELECT)),
             max2(max2(C_LATCH, C_SETTLE), C_FINAL));
    localparam int CW = (C_MAX < 2) ? 1 : $clog2(C_MAX);

    seq_state_t    state_d;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          expired;

    dbg2w_hold_timer #(.CW(CW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (expired)
    );

    dbg2w_seq_fsm #(
        .CW          (CW),
        .LD_TRST     (CW'(C_TRST - 1)),
        .LD_SETUP    (CW'(C_SETUP - 1)),
        .LD_ACTIVATE (CW'(C_ACTIVATE - 1)),
        .LD_SELECT   (CW'(C_SELECT - 1)),
        .LD_LATCH    (CW'(C_LATCH - 1)),
        .LD_SETTLE   (CW'(C_SETTLE - 1)),
        .LD_FINAL    (CW'(C_FINAL - 1))
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .expired_i  (expired),
        .state_d_o  (state_d),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    dbg2w_pin_drv u_pins (
        .clk          (clk),
        .rst_n        (rst_n),
        .state_d_i    (state_d),
        .tck_o        (tck_o),
        .tdio_o       (tdio_o),
        .oe_o         (pins_oe_o),
        .engine_sel_o (engine_sel_o)
    );

    AST_BUSY_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> pins_oe_o); // R8

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !engine_sel_o) |-> (!pins_oe_o && !done_o)); // R1

    AST_START_FIRST_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && pins_oe_o && !tck_o && tdio_o)); // R2

endmodule

// File: tb/tb_dbg2w_entry_seq.sv
`timescale 1ns/1ps
module tb_dbg2w_entry_seq;

    localparam int unsigned TB_HZ      = 2_000_000;
    localparam int          CLK_PERIOD = 500;
    localparam int          LIMIT      = 60_000;

    function automatic longint cyc(longint ns);
        return (longint'(TB_HZ) * ns + 64'd999_999_999) / 64'd1_000_000_000;
    endfunction

    localparam longint E_LOW1  = cyc(4_000_000) + cyc(1_000);
    localparam longint E_HIGH1 = cyc(20_000_000) + cyc(60_000);
    localparam longint E_LATCH = cyc(1_000);
    localparam longint E_HIGH2 = cyc(60_000) + cyc(5_000_000);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic tck_o, tdio_o, pins_oe_o, engine_sel_o, busy_o, done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int tdio_bad, busy_bad;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg2w_entry_seq #(.CLK_HZ(TB_HZ)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .tck_o        (tck_o),
        .tdio_o       (tdio_o),
        .pins_oe_o    (pins_oe_o),
        .engine_sel_o (engine_sel_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counts samples while tck equals lvl (and, if stop_on_done, done is low).
    task automatic count_run(input logic lvl, input bit stop_on_done,
                             input int poke, output longint n);
        n = 0;
        while (tck_o == lvl && !(stop_on_done && done_o) && n < LIMIT) begin
            if (pins_oe_o && !tdio_o) tdio_bad++;
            if (!busy_o) busy_bad++;
            start_i = (n == longint'(poke));
            n++;
            @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(!busy_o, "R1 busy", busy_o, 0);
        chk(!done_o, "R1 done", done_o, 0);
        chk(!pins_oe_o, "R1 oe", pins_oe_o, 0);
        chk(!engine_sel_o, "R1 engine_sel", engine_sel_o, 0);
    endtask

    // One full script; poke_low/poke_high give sample indices for a busy start.
    task automatic t_script(input string tag, input int poke_low, input int poke_high);
        longint n;
        tdio_bad = 0;
        busy_bad = 0;
        start_i = 1'b1;
        @(negedge clk);
        chk(busy_o && pins_oe_o, {"R2 driven ", tag}, {busy_o, pins_oe_o}, 3);
        chk(!tck_o && tdio_o, {"R2 levels ", tag}, {tck_o, tdio_o}, 1);
        chk(!engine_sel_o, {"R2 engine_sel ", tag}, engine_sel_o, 0);
        count_run(1'b0, 1'b0, poke_low, n);
        chk(n == E_LOW1, {"R3 reset low ", tag}, n, E_LOW1);
        count_run(1'b1, 1'b0, poke_high, n);
        chk(n == E_HIGH1, {"R4 activate high ", tag}, n, E_HIGH1);
        if (poke_high >= 0)
            chk(n == E_HIGH1, {"R9 busy start ignored ", tag}, n, E_HIGH1);
        count_run(1'b0, 1'b0, -1, n);
        chk(n == E_LATCH, {"R5 latch width ", tag}, n, E_LATCH);
        chk(n * CLK_PERIOD >= 25 && n * CLK_PERIOD <= 7000,
            {"R5 latch window ns ", tag}, n * CLK_PERIOD, 1000);
        count_run(1'b1, 1'b1, -1, n);
        chk(n == E_HIGH2, {"R6 settle high ", tag}, n, E_HIGH2);
        chk(done_o, {"R6 done rises ", tag}, done_o, 1);
        chk(!busy_o, {"R8 busy low at done ", tag}, busy_o, 0);
        chk(busy_bad == 0, {"R8 busy through script ", tag}, busy_bad, 0);
        chk(tdio_bad == 0, {"R7 data high ", tag}, tdio_bad, 0);
        chk(!pins_oe_o && engine_sel_o, {"R10 handoff ", tag},
            {pins_oe_o, engine_sel_o}, 1);
        @(negedge clk);
        chk(!done_o, {"R8 done one cycle ", tag}, done_o, 0);
        repeat (10) @(negedge clk);
        chk(!pins_oe_o && engine_sel_o && !busy_o, {"R10 handoff held ", tag},
            {pins_oe_o, engine_sel_o, busy_o}, 2);
    endtask

    initial begin
        t_reset();
        t_script("from idle", -1, -1);
        t_script("from handoff", 0, 500);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190_000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 190_000, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule